// File: doc/BRIEF.md
# Audio Sample FIFO with Level Reporting

This block sits between a 32-bit register-style host port and a serial audio frame engine. It holds a transmit queue, which the host fills and the frame engine drains, and a receive queue, which the frame engine fills and the host drains. Each queue entry is one 16-bit sample. On the host side the sample sits in the upper half of the 32-bit word. The host can see how many transmit slots are free and how many receive samples are waiting. It gets an interrupt from a programmable transmit threshold, from receive data being present and from a transmit underrun. It can empty either queue with a flush bit. It can also read or load a running count of samples moved in each direction.

The host port uses single-cycle strobes. A write takes effect at the clock edge where `host_wr` is high. A read returns its data on `host_rdata` from the edge where `host_rd` is high. The host port has eight word registers, selected by `host_addr`: 0 control, 1 levels, 2 interrupt status, 3 interrupt enable, 4 transmit data (write only), 5 receive data (read only), 6 transmit sample count, 7 receive sample count.

The frame-engine side uses valid/ready. A sample moves at an edge where valid and ready are both high. Once `tx_valid` is high, it stays high and `tx_sample` does not change until `tx_ready` takes the sample. The only exception is a transmit flush. `rx_ready` goes low when the receive queue is full or a receive flush is held, and the engine must then hold its sample.

Top module: `audio_sample_fifo`

## Requirements
- R1: A host write to address 4 queues bits 31:16 of the word as one sample, so the sample's high byte comes from bits 31:24 and its low byte from bits 23:16. A host read of address 5 returns the oldest receive sample in bits 31:16, with zeros in bits 15:0.
- R2: Both queues are first-in first-out. The transmit queue holds 128 samples and the receive queue holds 32. A host write to a full transmit queue is dropped.
- R3: A read of address 1 returns the free transmit slots in bits 23:16 and the occupied receive slots in bits 5:0. All other bits read zero.
- R4: Control bits 6:0 hold the transmit threshold, which resets to 64. Interrupt status bit 4 is set on every cycle where the number of free transmit slots is greater than the threshold.
- R5: Interrupt status bit 0 is set on every cycle where the receive queue is not empty.
- R6: Interrupt status bit 6 is set when `tx_ready` is high while `tx_valid` is low.
- R7: Writing 1 to an interrupt status bit at address 2 clears it, and writing 0 leaves it unchanged. If the condition that sets a bit is present in the same cycle as the clear, the bit stays set.
- R8: Interrupt enable bits at address 3 use the same bit positions as the status bits. `irq` is high while any status bit and its enable bit are both set.
- R9: Control bit 8 flushes the transmit queue and control bit 9 flushes the receive queue. While a flush bit is 1, that queue is held empty: `tx_valid` is low for a transmit flush, and `rx_ready` is low for a receive flush. Software then writes the bit back to 0.
- R10: The counters at addresses 6 and 7 count transmit and receive handshakes. A host write loads the written value, so writing zero restarts a count.
- R11: Reading address 5 while the receive queue is empty returns zero and leaves the queue unchanged.
- R12: `tx_valid` and `tx_sample` hold steady until `tx_ready` takes the sample. `rx_ready` is low while the receive queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| tx_valid | output | 1 | Transmit sample available |
| tx_ready | input | 1 | Frame engine takes the transmit sample |
| tx_sample | output | 16 | Oldest transmit sample |
| rx_valid | input | 1 | Frame engine offers a receive sample |
| rx_ready | output | 1 | Receive queue can accept a sample |
| rx_sample | input | 16 | Receive sample |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count shows on the level register on the next read. It also shows as a threshold or receive-available status bit that is set or missing one cycle after the count changes. Pointer corruption shows as samples leaving out of order on `tx_sample` or at address 5, on the very next transfer. Errors in the clear or set priority of the status bits show on the first status read after a write-one-to-clear.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LEVEL = 3'd1;
  localparam logic [2:0] A_ISTA  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_TXD   = 3'd4;
  localparam logic [2:0] A_RXD   = 3'd5;
  localparam logic [2:0] A_TXCNT = 3'd6;
  localparam logic [2:0] A_RXCNT = 3'd7;

  localparam int unsigned IRQ_RXA = 0;
  localparam int unsigned IRQ_TXE = 4;
  localparam int unsigned IRQ_UND = 6;
  localparam int unsigned IRQ_W   = 8;

  localparam int unsigned CTRL_FTX = 8;
  localparam int unsigned CTRL_FRX = 9;

  localparam int unsigned SAMPLE_W = 16;
endpackage

// File: rtl/afifo_sync_fifo.sv
module afifo_sync_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full && !clr) |=> count == $past(count) + 1'b1);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/afifo_irq.sv
module afifo_irq import afifo_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_rxa,
  input  logic              set_txe,
  input  logic              set_und,
  input  logic              clr_we,
  input  logic [IRQ_W-1:0]  clr_mask,
  input  logic [IRQ_W-1:0]  ien,
  output logic [IRQ_W-1:0]  ista,
  output logic              irq
);
  logic [IRQ_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_RXA] = set_rxa;
    set_vec[IRQ_TXE] = set_txe;
    set_vec[IRQ_UND] = set_und;
    clr_vec          = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ista <= '0;
    else        ista <= (ista & ~clr_vec) | set_vec;
  end

  assign irq = |(ista & ien);

  p_underrun_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_und |=> ista[IRQ_UND]);
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[IRQ_TXE] && set_txe) |=> ista[IRQ_TXE]);
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo import afifo_pkg::*; #(
  parameter int unsigned TX_DEPTH = 128,
  parameter int unsigned RX_DEPTH = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LVL_W    = 7,
  parameter int unsigned LVL_RST  = 64,
  localparam int unsigned TX_CW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] tx_sample,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [15:0] rx_sample,
  output logic        irq
);
  logic [LVL_W-1:0] lvl;
  logic             ftx, frx;
  logic [IRQ_W-1:0] ien, ista;
  logic [CNT_W-1:0] tx_cnt_smp, rx_cnt_smp;
  logic [TX_CW-1:0] tx_cnt, tx_free;
  logic [RX_CW-1:0] rx_cnt;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [SAMPLE_W-1:0] rx_head;
  logic             tx_hs, rx_hs, rd_rxd;
  logic [31:0]      level_word, ctrl_word;

  assign tx_hs   = tx_valid && tx_ready;
  assign rx_hs   = rx_valid && rx_ready;
  assign rd_rxd  = host_rd && (host_addr == A_RXD);
  assign tx_valid = !tx_empty && !ftx;
  assign rx_ready = !rx_full && !frx;
  assign tx_free = TX_CW'(TX_DEPTH) - tx_cnt;

  afifo_sync_fifo #(.WIDTH(SAMPLE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(ftx),
    .push(host_wr && (host_addr == A_TXD)), .push_data(host_wdata[31:16]),
    .pop(tx_hs), .head(tx_sample), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full));

  afifo_sync_fifo #(.WIDTH(SAMPLE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(frx),
    .push(rx_hs), .push_data(rx_sample),
    .pop(rd_rxd), .head(rx_head), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full));

  afifo_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_rxa(!rx_empty),
    .set_txe(32'(tx_free) > 32'(lvl)),
    .set_und(tx_ready && !tx_valid),
    .clr_we(host_wr && (host_addr == A_ISTA)),
    .clr_mask(host_wdata[IRQ_W-1:0]),
    .ien(ien), .ista(ista), .irq(irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= LVL_W'(LVL_RST);
      ftx <= 1'b0;
      frx <= 1'b0;
      ien <= '0;
    end else if (host_wr) begin
      case (host_addr)
        A_CTRL: begin
          lvl <= host_wdata[LVL_W-1:0];
          ftx <= host_wdata[CTRL_FTX];
          frx <= host_wdata[CTRL_FRX];
        end
        A_IEN:   ien <= host_wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt_smp <= '0;
      rx_cnt_smp <= '0;
    end else begin
      if (host_wr && host_addr == A_TXCNT) tx_cnt_smp <= host_wdata[CNT_W-1:0];
      else if (tx_hs)                      tx_cnt_smp <= tx_cnt_smp + 1'b1;
      if (host_wr && host_addr == A_RXCNT) rx_cnt_smp <= host_wdata[CNT_W-1:0];
      else if (rx_hs)                      rx_cnt_smp <= rx_cnt_smp + 1'b1;
    end
  end

  always_comb begin
    level_word        = '0;
    level_word[23:16] = 8'(tx_free);
    level_word[5:0]   = 6'(rx_cnt);
    ctrl_word         = '0;
    ctrl_word[LVL_W-1:0] = lvl;
    ctrl_word[CTRL_FTX]  = ftx;
    ctrl_word[CTRL_FRX]  = frx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        A_CTRL:  host_rdata <= ctrl_word;
        A_LEVEL: host_rdata <= level_word;
        A_ISTA:  host_rdata <= 32'(ista);
        A_IEN:   host_rdata <= 32'(ien);
        A_RXD:   host_rdata <= rx_empty ? 32'd0 : {rx_head, 16'h0000};
        A_TXCNT: host_rdata <= 32'(tx_cnt_smp);
        A_RXCNT: host_rdata <= 32'(rx_cnt_smp);
        default: host_rdata <= '0;
      endcase
    end
  end

  p_empty_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_empty) |=> host_rdata == 32'd0);
  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(host_wr && host_addr == A_CTRL))
      |=> tx_valid && $stable(tx_sample));
  p_rx_full_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);
endmodule

// File: tb/audio_sample_fifo_bench.sv
`timescale 1ns/1ps
module audio_sample_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_sample;
  logic        rx_valid = 1'b0, rx_ready;
  logic [15:0] rx_sample = '0;
  logic        irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  audio_sample_fifo u_audio_sample_fifo (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sample(tx_sample),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sample(rx_sample), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 tx_valid after reset", 32'(tx_valid), 0);
    check("R12 rx_ready after reset", 32'(rx_ready), 1);
    check("R8 irq after reset", 32'(irq), 0);
    rd(3'd0, d); check("R4 threshold reset 64", d, 32'd64);
    rd(3'd1, d); check("R3 level after reset", d, 32'h0080_0000);
  endtask

  task automatic t_pack();
    logic [31:0] d;
    wr(3'd6, 0);
    wr(3'd4, 32'hA5C3_1234);
    check("R1 tx sample from upper half", 32'(tx_sample), 32'h0000_A5C3);
    check("R1 tx_valid", 32'(tx_valid), 1);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R12 tx drained", 32'(tx_valid), 0);
    rd(3'd6, d); check("R10 tx count one", d, 1);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    int bad = 0;
    wr(3'd6, 0);
    for (int i = 0; i < 130; i++) wr(3'd4, {16'(16'h4000 + i), 16'hFFFF});
    rd(3'd1, d); check("R2 tx full, extra writes dropped", d, 0);
    repeat (3) @(negedge clk);
    check("R12 tx sample held without ready", 32'(tx_sample), 32'h4000);
    check("R12 tx valid held without ready", 32'(tx_valid), 1);
    @(negedge clk); tx_ready = 1'b1;
    for (int i = 0; i < 128; i++) begin
      if (tx_sample !== 16'(16'h4000 + i)) bad++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R2 tx order of 128 samples", bad, 0);
    rd(3'd6, d); check("R10 tx count after drain", d, 128);
    rd(3'd2, d); check("R6 no underrun while samples flow", 32'(d[6]), 0);
    wr(3'd6, 0);
    rd(3'd6, d); check("R10 tx count cleared by write", d, 0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(3'd2, 32'h10);
    rd(3'd2, d); check("R7 clear loses to active threshold", 32'(d[4]), 1);
    for (int i = 0; i < 70; i++) wr(3'd4, {16'(i), 16'h0});
    wr(3'd2, 32'h10);
    rd(3'd2, d); check("R4 free 58 not above 64", 32'(d[4]), 0);
    rd(3'd1, d); check("R3 free 58 reported", d, 32'h003A_0000);
    wr(3'd0, 57);
    rd(3'd2, d); check("R4 free 58 above 57", 32'(d[4]), 1);
    wr(3'd0, 64 | (1 << 8));
    check("R9 tx flush drops valid", 32'(tx_valid), 0);
    rd(3'd1, d); check("R9 tx flush frees all", d, 32'h0080_0000);
    wr(3'd0, 64);
    wr(3'd4, 32'h1111_0000);
    check("R9 tx usable after flush", 32'(tx_sample), 32'h1111);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    wr(3'd2, 32'h40);
    rd(3'd2, d); check("R6 underrun clear baseline", 32'(d[6]), 0);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    rd(3'd2, d); check("R6 underrun on empty request", 32'(d[6]), 1);
    wr(3'd2, 32'h01);
    rd(3'd2, d); check("R7 writing other bits keeps underrun", 32'(d[6]), 1);
    wr(3'd2, 32'h40);
    rd(3'd2, d); check("R7 underrun cleared", 32'(d[6]), 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    int bad = 0;
    wr(3'd7, 0);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sample = 16'(16'h7700 + i * 5);
    end
    @(negedge clk); rx_sample = 16'hDEAD;
    check("R12 rx_ready low when full", 32'(rx_ready), 0);
    repeat (2) @(negedge clk);
    rx_valid = 1'b0;
    rd(3'd1, d); check("R2 rx holds 32", d, 32'h0080_0020);
    rd(3'd2, d); check("R5 rx available bit", 32'(d[0]), 1);
    rd(3'd7, d); check("R10 rx count", d, 32);
    for (int i = 0; i < 32; i++) begin
      rd(3'd5, d);
      if (d !== {16'(16'h7700 + i * 5), 16'h0}) bad++;
    end
    check("R1 rx order and packing", bad, 0);
    rd(3'd5, d); check("R11 empty read zero", d, 0);
    rd(3'd1, d); check("R11 empty read keeps level", d, 32'h0080_0000);
    wr(3'd2, 32'h01);
    rd(3'd2, d); check("R5 bit clears once empty", 32'(d[0]), 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3'd3, 32'h01);
    check("R8 masked bits do not interrupt", 32'(irq), 0);
    @(negedge clk); rx_valid = 1'b1; rx_sample = 16'h0F0F;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 irq from rx available", 32'(irq), 1);
    rd(3'd5, d); check("R1 single rx word", d, 32'h0F0F_0000);
    wr(3'd2, 32'h01);
    check("R8 irq drops after clear", 32'(irq), 0);
    wr(3'd3, 32'h10);
    check("R8 irq from tx threshold", 32'(irq), 1);
    wr(3'd3, 0);
    check("R8 irq off when disabled", 32'(irq), 0);
  endtask

  task automatic t_rxflush();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sample = 16'(i);
    end
    @(negedge clk); rx_valid = 1'b0;
    wr(3'd0, 64 | (1 << 9));
    check("R9 rx_ready low in flush", 32'(rx_ready), 0);
    rd(3'd1, d); check("R9 rx flushed", d, 32'h0080_0000);
    wr(3'd0, 64);
    check("R9 rx_ready back after flush", 32'(rx_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pack();
    t_fill();
    t_thresh();
    t_underrun();
    t_rx();
    t_irq();
    t_rxflush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule